// File: doc/BRIEF.md
# Ramped-Duty NCO Bitstream Generator

This block produces a one-bit stream that imitates the output of a sigma-delta modulator, for use as test stimulus in front of decimation filters. It has a 32-bit phase accumulator. On every enabled clock it adds a frequency word to the phase, and the carry out of that add becomes the output bit. Over a long run, the density of ones is therefore the frequency word divided by 2^32.

The frequency word moves slowly and automatically. Every DIV enabled clocks, a programmable step is added to it or subtracted from it. The word is confined to a window from one seventh to six sevenths of full scale, which matches the limited duty range of a real modulator. When the word reaches an edge of that window, it is clamped there. Depending on a mode input, the sweep then either turns around or halts. While the block is disabled, the sweep direction is taken from an input pin. A step of zero holds the word, so the block can also serve as a fixed-density source.

Top module: `duty_ramp_nco`

## Requirements
- R1: While reset is high, and on the first cycle after it, `freq_o` equals the lower bound floor(2^32/7) = 0x24924924 and `bit_o` is 0. The phase accumulator is cleared to zero.
- R2: On each clock with `en_i` high, the phase becomes (phase + `freq_o`) mod 2^32. The carry of that add is driven on `bit_o` from the following cycle.
- R3: With the word held constant over 1024 consecutive enabled clocks, the number of ones on `bit_o` is within 1 of floor(1024·word/2^32).
- R4: `freq_o` changes only after the DIV-th enabled clock counted from the rising edge of `en_i`, and after every DIV enabled clocks from then on. An unclamped change is exactly +`step_i` (ramp up) or −`step_i` (ramp down).
- R5: `freq_o` always lies between 0x24924924 and the upper bound floor(6·2^32/7) = 0xDB6DB6DB, both inclusive.
- R6: On an upward step where `step_i` ≥ upper bound − `freq_o`, `freq_o` becomes exactly the upper bound.
- R7: On a downward step where `step_i` ≥ `freq_o` − lower bound, `freq_o` becomes exactly the lower bound.
- R8: With `bounce_i` = 1, a clamp at either bound reverses the sweep direction.
- R9: With `bounce_i` = 0, a clamp stops the sweep, and `freq_o` stays at the bound until `en_i` is lowered.
- R10: While `en_i` is low, `freq_o` and the phase hold, `bit_o` is 0, and the sweep direction is loaded from `dir_dn_i` (1 = down, 0 = up).
- R11: A `step_i` of zero leaves `freq_o` unchanged and causes no clamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; one output bit per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low idles and loads the direction |
| step_i | input | ACC_W (32) | Frequency word increment applied every DIV enabled clocks |
| dir_dn_i | input | 1 | Initial sweep direction, sampled while idle (1 = down) |
| bounce_i | input | 1 | 1: reverse at a bound; 0: stop at a bound |
| bit_o | output | 1 | Carry-out bitstream |
| freq_o | output | ACC_W (32) | Current frequency word |

## Verification
The assertions assume that `step_i`, `dir_dn_i` and `bounce_i` only change on the clock edge and only between sweeps. The stop and reversal properties also assume that `step_i` is steady while a clamp is being resolved. The bench meets these assumptions by changing those inputs only while `en_i` is low, one cycle or more before it rises. Its step values are chosen so that both a long bouncing sweep and a one-step clamp occur. It holds the word with a zero step during the density windows, so that the count tolerance applies.

// File: rtl/nco_ramp_pkg.sv
package nco_ramp_pkg;

  // Fraction num/den of 2^w, rounded down (w up to 48).
  function automatic logic [63:0] frac_of_scale(input int w, input int num, input int den);
    logic [63:0] full;
    full = 64'd1 << w;
    return (full * 64'(num)) / 64'(den);
  endfunction

  // Upward move reaches or passes the upper bound.
  function automatic logic up_hits(input logic [63:0] cur, input logic [63:0] step,
                                   input logic [63:0] hi);
    return (step != 64'd0) && (step >= (hi - cur));
  endfunction

  // Downward move reaches or passes the lower bound.
  function automatic logic dn_hits(input logic [63:0] cur, input logic [63:0] step,
                                   input logic [63:0] lo);
    return (step != 64'd0) && (step >= (cur - lo));
  endfunction

endpackage

// File: rtl/nco_tick_div.sv
module nco_tick_div #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_every
      assign tick_o = en_i;
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic             last_w;
      assign last_w = (cnt_q == CNT_W'(DIV - 1));
      assign tick_o = en_i && last_w;
      always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
          cnt_q <= '0;
        end else if (last_w) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/nco_freq_ramp.sv
module nco_freq_ramp
  import nco_ramp_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter logic [ACC_W-1:0] LO = '0,
  parameter logic [ACC_W-1:0] HI = '1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic             dir_dn_i,
  input  logic             bounce_i,
  output logic [ACC_W-1:0] freq_o,
  output logic             dir_dn_o,
  output logic             stopped_o,
  output logic             clamp_o
);
  logic [ACC_W-1:0] freq_q;
  logic             dn_q;
  logic             stop_q;
  logic             move_w;
  logic             hit_w;
  logic [ACC_W-1:0] next_w;

  assign move_w = en_i && tick_i && !stop_q && (step_i != '0);
  assign hit_w  = dn_q ? dn_hits(64'(freq_q), 64'(step_i), 64'(LO))
                       : up_hits(64'(freq_q), 64'(step_i), 64'(HI));
  assign next_w = dn_q ? (freq_q - step_i) : (freq_q + step_i);
  assign clamp_o = move_w && hit_w;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      freq_q <= LO;
      dn_q   <= 1'b0;
      stop_q <= 1'b0;
    end else if (!en_i) begin
      dn_q   <= dir_dn_i;
      stop_q <= 1'b0;
    end else if (move_w) begin
      if (hit_w) begin
        freq_q <= dn_q ? LO : HI;
        if (bounce_i) dn_q <= ~dn_q;
        else          stop_q <= 1'b1;
      end else begin
        freq_q <= next_w;
      end
    end
  end

  assign freq_o    = freq_q;
  assign dir_dn_o  = dn_q;
  assign stopped_o = stop_q;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] freq_i,
  output logic             bit_o
);
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W:0]   sum_w;

  assign sum_w = {1'b0, phase_q} + {1'b0, freq_i};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q <= '0;
      bit_o   <= 1'b0;
    end else if (!en_i) begin
      bit_o   <= 1'b0;
    end else begin
      phase_q <= sum_w[ACC_W-1:0];
      bit_o   <= sum_w[ACC_W];
    end
  end
endmodule

// File: rtl/duty_ramp_nco.sv
module duty_ramp_nco
  import nco_ramp_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int DIV     = 8,
  parameter int LO_NUM  = 1,
  parameter int HI_NUM  = 6,
  parameter int WIN_DEN = 7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [ACC_W-1:0] step_i,
  input  logic             dir_dn_i,
  input  logic             bounce_i,
  output logic             bit_o,
  output logic [ACC_W-1:0] freq_o
);
  localparam logic [63:0] LO_FULL = frac_of_scale(ACC_W, LO_NUM, WIN_DEN);
  localparam logic [63:0] HI_FULL = frac_of_scale(ACC_W, HI_NUM, WIN_DEN);
  localparam logic [ACC_W-1:0] LO_WORD = LO_FULL[ACC_W-1:0];
  localparam logic [ACC_W-1:0] HI_WORD = HI_FULL[ACC_W-1:0];

  logic tick_w;
  logic clamp_w;
  logic dir_dn_w;
  logic stopped_w;

  nco_tick_div #(.DIV(DIV)) u_div (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .tick_o(tick_w)
  );

  nco_freq_ramp #(.ACC_W(ACC_W), .LO(LO_WORD), .HI(HI_WORD)) u_ramp (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .tick_i   (tick_w),
    .step_i   (step_i),
    .dir_dn_i (dir_dn_i),
    .bounce_i (bounce_i),
    .freq_o   (freq_o),
    .dir_dn_o (dir_dn_w),
    .stopped_o(stopped_w),
    .clamp_o  (clamp_w)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .freq_i(freq_o),
    .bit_o (bit_o)
  );
endmodule

// File: rtl/nco_ramp_chk.sv
module nco_ramp_chk #(
  parameter int ACC_W = 32,
  parameter logic [ACC_W-1:0] LO = '0,
  parameter logic [ACC_W-1:0] HI = '1
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             en_i,
  input logic             bounce_i,
  input logic             bit_o,
  input logic [ACC_W-1:0] freq_o,
  input logic             tick_w,
  input logic             clamp_w,
  input logic             dir_dn_w,
  input logic             stopped_w
);
  p_in_window_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (freq_o >= LO) && (freq_o <= HI));

  p_no_tick_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick_w |=> $stable(freq_o));

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> ($stable(freq_o) && !bit_o));

  p_clamp_up_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (clamp_w && !dir_dn_w) |=> (freq_o == HI));

  p_clamp_dn_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (clamp_w && dir_dn_w) |=> (freq_o == LO));

  p_bounce_turn_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (clamp_w && bounce_i) |=> (dir_dn_w != $past(dir_dn_w)));

  p_stop_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (stopped_w && en_i) |=> $stable(freq_o));
endmodule

bind duty_ramp_nco nco_ramp_chk #(.ACC_W(ACC_W), .LO(LO_WORD), .HI(HI_WORD)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .en_i     (en_i),
  .bounce_i (bounce_i),
  .bit_o    (bit_o),
  .freq_o   (freq_o),
  .tick_w   (tick_w),
  .clamp_w  (clamp_w),
  .dir_dn_w (dir_dn_w),
  .stopped_w(stopped_w)
);

// File: tb/duty_ramp_nco_test.sv
module duty_ramp_nco_test;
  localparam int     PERIOD = 10;
  localparam int     DIV    = 8;
  localparam longint FULL   = 64'sd1 << 32;
  localparam longint LOW    = 64'sh24924924;
  localparam longint HIGH   = 64'shDB6DB6DB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] step = 32'd0;
  logic        dir_dn = 1'b0;
  logic        bounce = 1'b0;
  logic        bit_o;
  logic [31:0] freq_o;

  int checks = 0;
  int bad = 0;

  always #(PERIOD/2) clk = ~clk;

  duty_ramp_nco #(.DIV(DIV)) uut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .step_i(step),
    .dir_dn_i(dir_dn), .bounce_i(bounce), .bit_o(bit_o), .freq_o(freq_o)
  );

  // Behavioural reference, written from the requirements.
  longint m_freq = LOW, m_phase = 0, m_bit = 0, m_cnt = 0;
  bit     m_dn = 0, m_stop = 0;

  always @(posedge clk) begin
    longint s, st;
    st = longint'(step);
    if (rst) begin
      m_freq = LOW; m_phase = 0; m_bit = 0; m_cnt = 0; m_dn = 0; m_stop = 0;
    end else if (!en) begin
      m_bit = 0; m_cnt = 0; m_dn = dir_dn; m_stop = 0;
    end else begin
      s = m_phase + m_freq;
      m_bit = s / FULL;
      m_phase = s % FULL;
      if (m_cnt == DIV - 1) begin
        m_cnt = 0;
        if (!m_stop && st != 0) begin
          if (!m_dn && m_freq + st >= HIGH) begin
            m_freq = HIGH;
            if (bounce) m_dn = 1; else m_stop = 1;
          end else if (m_dn && m_freq - st <= LOW) begin
            m_freq = LOW;
            if (bounce) m_dn = 0; else m_stop = 1;
          end else begin
            m_freq = m_dn ? m_freq - st : m_freq + st;
          end
        end
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison (R2 bit, R4 word, R5 window).
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(bit_o == m_bit[0], "R2 bit stream", bit_o, m_bit);
      chk(freq_o == m_freq[31:0], "R4 word sequence", freq_o, m_freq);
      chk(freq_o >= LOW && freq_o <= HIGH, "R5 window", freq_o, LOW);
    end
  end

  task automatic idle(input int n);
    @(negedge clk); en = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic density(input string tag);
    int ones = 0;
    longint w, exp;
    w = longint'(freq_o);
    step = 0;
    @(negedge clk); en = 1;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      ones += int'(bit_o);
    end
    exp = (w * 1024) / FULL;
    chk((ones >= exp - 1) && (ones <= exp + 1), tag, ones, exp);
    chk(freq_o == w[31:0], "R11 zero step holds", freq_o, w);
    idle(2);
  endtask

  task automatic run_body();
    bit saw_hi = 0, saw_turn = 0;
    longint prev;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(freq_o == LOW[31:0], "R1 reset word", freq_o, LOW);
    chk(bit_o == 1'b0, "R1 reset bit", bit_o, 0);
    rst = 0;
    @(negedge clk);
    chk(freq_o == LOW[31:0], "R1 word after reset", freq_o, LOW);
    cmp_on = 1;

    // R3 density at the lower bound
    density("R3 density low");

    // R4 first step timing, then R8 bounce
    step = 32'h0100_0000; bounce = 1; dir_dn = 0;
    idle(2);
    en = 1;
    repeat (DIV - 1) @(negedge clk);
    chk(freq_o == LOW[31:0], "R4 no change before DIV", freq_o, LOW);
    @(negedge clk);
    chk(freq_o == LOW[31:0] + 32'h0100_0000, "R4 step after DIV", freq_o, LOW + 64'h0100_0000);
    prev = longint'(freq_o);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (freq_o == HIGH[31:0]) saw_hi = 1;
      if (saw_hi && longint'(freq_o) < prev) saw_turn = 1;
      prev = longint'(freq_o);
    end
    chk(saw_hi, "R6 reached upper bound", saw_hi, 1);
    chk(saw_turn, "R8 reversed after bound", saw_turn, 1);

    // R6 and R9: large step, stop mode, upward
    idle(2);
    step = 32'h4000_0000; bounce = 0; dir_dn = 0;
    idle(2);
    en = 1;
    repeat (6 * DIV) @(negedge clk);
    chk(freq_o == HIGH[31:0], "R6 clamp up", freq_o, HIGH);
    repeat (4 * DIV) @(negedge clk);
    chk(freq_o == HIGH[31:0], "R9 stays stopped", freq_o, HIGH);

    // R3 density at the upper bound
    idle(2);
    density("R3 density high");

    // R10 idle behaviour
    step = 32'h0800_0000;
    idle(1);
    prev = longint'(freq_o);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (freq_o != prev[31:0] || bit_o) begin
        chk(0, "R10 idle hold", freq_o, prev);
      end
    end
    chk(freq_o == prev[31:0] && !bit_o, "R10 idle hold", freq_o, prev);

    // R7: downward, stop mode
    step = 32'h3000_0000; dir_dn = 1; bounce = 0;
    idle(2);
    en = 1;
    repeat (8 * DIV) @(negedge clk);
    chk(freq_o == LOW[31:0], "R7 clamp down", freq_o, LOW);

    // R3 density in the middle of the window
    step = 32'h1234_5678; dir_dn = 0; bounce = 0;
    idle(2);
    en = 1;
    repeat (5 * DIV) @(negedge clk);
    idle(2);
    density("R3 density mid");
  endtask

  initial begin
    fork
      run_body();
      begin
        repeat (150000) @(posedge clk);
        bad++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    cmp_on = 0;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule